// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a small 32-bit processor core that completes one instruction per clock. Instruction words and data words sit in two separate internal arrays. Each clock edge commits everything the current instruction does: the next program counter, one register write and one data-memory write. The core handles five register-to-register operations (add, sub, and, or, signed set-less-than), an add-immediate, a word load, a word store, a branch on equal, a direct jump, and a jump that saves its return address in register 31.

The ALU is steered by a two-level decoder. A main decoder sorts the opcode into one of eight instruction classes: ARITH, IMM, LOAD, STORE, BRANCH, JUMP, LINK and NOP. From that class it produces the datapath selects and a 2-bit operation class with three values: force-add, force-subtract, and use-function-field. A second decoder turns the operation class and the function field into the 3-bit ALU command. The only state-holding step is the program counter register.

To use the core, hold reset high and write the program and any initial data through the load port. Then release reset. The core starts fetching at address 0. Stores are visible on a dedicated store-observation port in the cycle in which they commit.

Top module: `scc_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 at every clock edge, `st_en_o` is 0 and no register is written. In that state a high `ld_imem_we` or `ld_dmem_we` writes `ld_data` into the instruction or data word selected by `ld_addr`.
- R2: Field layout is fixed as follows: opcode in [31:26], rs in [25:21], rt in [20:16], rd in [15:11], function in [5:0], immediate in [15:0]. R-type results go to rd. Add-immediate and load results go to rt.
- R3: R-type (opcode 000000) selects its operation by function code: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than.
- R4: Set-less-than compares rs and rt as signed values and writes 1 or 0.
- R5: Add-immediate (opcode 001000) adds the sign-extended 16-bit immediate to rs.
- R6: Load (100011) and store (101011) use the byte address rs + sign-extended immediate and select data word [N+1:2] of it. A store shows `st_en_o`=1, that address on `st_addr_o` and rt on `st_data_o`.
- R7: Branch-on-equal (000100) moves the PC to PC+4+(sign-extended immediate × 4) when rs equals rt. Otherwise the PC moves to PC+4, which is also the next PC for every non-jump instruction.
- R8: Jump (000010) and jump-and-link (000011) set the PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R9: Jump-and-link writes PC+4 into register 31.
- R10: Register 0 reads as 0 whatever is written to it.
- R11: While `rst` is low, the load port has no effect on either memory.
- R12: A register written at a clock edge is read by the next instruction with its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| ld_imem_we | input | 1 | Load port write strobe for the instruction array |
| ld_dmem_we | input | 1 | Load port write strobe for the data array |
| ld_addr | input | 6 | Load port word index |
| ld_data | input | 32 | Load port write word |
| pc_o | output | 32 | Current program counter |
| st_en_o | output | 1 | A data store commits at the coming edge |
| st_addr_o | output | 32 | Byte address of that store |
| st_data_o | output | 32 | Word being stored |

## Verification
A wrong program counter shows up as a skipped or repeated store on the store port in the very next cycle, and a halted program then parks `pc_o` at the wrong address. A corrupted register, a bad destination select or a wrong ALU command cannot be seen until a later store reads that register, so each program stores its results straight away. In that way a defect shows at the ports within one or two instructions of its cause. Branch and jump defects move `pc_o` one edge after the instruction, so they also show up as missing or extra stores.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_LINK  = 6'b000011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } aluctl_e;

    typedef enum logic [2:0] {
        CLS_ARITH, CLS_IMM, CLS_LOAD, CLS_STORE,
        CLS_BRANCH, CLS_JUMP, CLS_LINK, CLS_NOP
    } iclass_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        logic   link;
        aluop_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scc_decode.sv
`timescale 1ns/1ps
module scc_decode
    import scc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    iclass_e iclass;

    // Opcode to instruction class
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: iclass = CLS_ARITH;
            OPC_ADDI:  iclass = CLS_IMM;
            OPC_LOAD:  iclass = CLS_LOAD;
            OPC_STORE: iclass = CLS_STORE;
            OPC_BEQ:   iclass = CLS_BRANCH;
            OPC_JUMP:  iclass = CLS_JUMP;
            OPC_LINK:  iclass = CLS_LINK;
            default:   iclass = CLS_NOP;
        endcase
    end

    // Class to datapath controls
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = AOP_ADD;
        unique case (iclass)
            CLS_ARITH: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = AOP_FUNCT;
            end
            CLS_IMM: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
            end
            CLS_LOAD: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            CLS_STORE: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            CLS_JUMP: begin
                ctrl.jump = 1'b1;
            end
            CLS_LINK: begin
                ctrl.jump      = 1'b1;
                ctrl.link      = 1'b1;
                ctrl.reg_write = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/scc_aluctl.sv
`timescale 1ns/1ps
module scc_aluctl
    import scc_pkg::*;
(
    input  aluop_e     alu_op,
    input  logic [5:0] funct,
    output aluctl_e    ctl
);

    always_comb begin
        unique case (alu_op)
            AOP_ADD: ctl = ALU_ADD;
            AOP_SUB: ctl = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  ctl = ALU_ADD;
                    FN_SUB:  ctl = ALU_SUB;
                    FN_AND:  ctl = ALU_AND;
                    FN_OR:   ctl = ALU_OR;
                    FN_SLT:  ctl = ALU_SLT;
                    default: ctl = ALU_ADD;
                endcase
            end
            default: ctl = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/scc_alu.sv
`timescale 1ns/1ps
module scc_alu
    import scc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluctl_e      ctl,
    output logic [W-1:0] res,
    output logic         zero
);

    always_comb begin
        unique case (ctl)
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: res = a + b;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/scc_regfile.sv
`timescale 1ns/1ps
module scc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));  // R12

endmodule

// File: rtl/scc_core.sv
`timescale 1ns/1ps
module scc_core
    import scc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_imem_we,
    input  logic           ld_dmem_we,
    input  logic [LDW-1:0] ld_addr,
    input  logic [31:0]    ld_data,
    output logic [31:0]    pc_o,
    output logic           st_en_o,
    output logic [31:0]    st_addr_o,
    output logic [31:0]    st_data_o
);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc, pc_next, pc4, br_tgt, jmp_tgt;
    logic [31:0] instr, imm_sx, alu_b, alu_res, mem_rdata;
    logic [31:0] rd1, rd2, wb_data;
    logic [4:0]  wb_addr;
    logic        alu_zero, rf_we;
    ctrl_t       ctrl;
    aluctl_e     alu_ctl;

    // Memories: load port only during reset
    always_ff @(posedge clk) begin
        if (rst && ld_imem_we) begin
            imem[ld_addr[IAW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst && ld_dmem_we) begin
            dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (!rst && ctrl.mem_write) begin
            dmem[alu_res[DAW+1:2]] <= rd2;
        end
    end

    assign instr     = imem[pc[IAW+1:2]];
    assign imm_sx    = {{16{instr[15]}}, instr[15:0]};
    assign mem_rdata = ctrl.mem_read ? dmem[alu_res[DAW+1:2]] : '0;

    scc_decode u_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    scc_aluctl u_actl (
        .alu_op (ctrl.alu_op),
        .funct  (instr[5:0]),
        .ctl    (alu_ctl)
    );

    assign alu_b = ctrl.alu_src ? imm_sx : rd2;

    scc_alu #(.W(32)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .ctl  (alu_ctl),
        .res  (alu_res),
        .zero (alu_zero)
    );

    assign rf_we   = ctrl.reg_write & ~rst;
    assign wb_addr = ctrl.link ? 5'd31 : (ctrl.reg_dst ? instr[15:11] : instr[20:16]);
    assign wb_data = ctrl.link ? pc4 : (ctrl.mem_to_reg ? mem_rdata : alu_res);

    scc_regfile #(.NREG(32), .W(32)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (wb_addr),
        .wd  (wb_data),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .rd1 (rd1),
        .rd2 (rd2)
    );

    // Program counter: the only sequencing register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    assign pc4     = pc + 32'd4;
    assign br_tgt  = pc4 + {imm_sx[29:0], 2'b00};
    assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump) begin
            pc_next = jmp_tgt;
        end else if (ctrl.branch && alu_zero) begin
            pc_next = br_tgt;
        end else begin
            pc_next = pc4;
        end
    end

    assign pc_o      = pc;
    assign st_en_o   = ctrl.mem_write & ~rst;
    assign st_addr_o = alu_res;
    assign st_data_o = rd2;

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !ctrl.branch) |=> (pc == $past(pc) + 32'd4));  // R7

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && rd1 == rd2) |=> (pc == $past(pc) + 32'd4 + {$past(imm_sx[29:0]), 2'b00}));  // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));  // R8

    AST_STORE_R0: assert property (@(posedge clk) disable iff (rst)
        (st_en_o && instr[20:16] == 5'd0) |-> (st_data_o == 32'd0));  // R10

endmodule

// File: tb/tb_scc_core.sv
`timescale 1ns/1ps
module tb_scc_core;

    localparam logic [5:0] O_R = 6'b000000, O_J = 6'b000010, O_JAL = 6'b000011;
    localparam logic [5:0] O_BEQ = 6'b000100, O_ADDI = 6'b001000;
    localparam logic [5:0] O_LW = 6'b100011, O_SW = 6'b101011;
    localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_AND = 6'b100100;
    localparam logic [5:0] F_OR = 6'b100101, F_SLT = 6'b101010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, st_addr_o, st_data_o;
    logic        st_en_o;

    int n_chk = 0, n_fail = 0, cap_n = 0, plen = 0;
    bit finished = 1'b0;
    logic [31:0] cap_a [32];
    logic [31:0] cap_d [32];
    logic [31:0] prog [64];

    scc_core dut (
        .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .st_en_o(st_en_o),
        .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst && st_en_o && cap_n < 32) begin
            cap_a[cap_n] = st_addr_o;
            cap_d[cap_n] = st_data_o;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [31:0] e_r(input logic [5:0] fn, input logic [4:0] rd, rs, rt);
        return {O_R, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] e_i(input logic [5:0] op, input logic [4:0] rt, rs,
                                        input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] e_j(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // Enter reset and load the program held in prog[0:plen-1]
    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < plen; i++) begin
            ld_imem_we = 1'b1;
            ld_addr    = 6'(i);
            ld_data    = prog[i];
            @(negedge clk);
        end
        ld_imem_we = 1'b0;
        plen = 0;
    endtask

    task automatic release_run(input int cycles);
        rst   = 1'b0;
        cap_n = 0;
        repeat (cycles) @(negedge clk);
        #0.5;
    endtask

    task automatic test_reset();
        emit(e_i(O_SW, 5'd0, 5'd0, 16'd0));
        emit(e_i(O_ADDI, 5'd1, 5'd0, 16'd1));
        emit(e_j(O_J, 26'd1));
        boot();
        chk("R1 pc in reset", pc_o, 32'd0);
        chk("R1 no store in reset", {31'd0, st_en_o}, 32'd0);
        release_run(3);
        chk("R1 store after release", 32'(cap_n), 32'd1);
        chk("R8 pc after jump", pc_o, 32'd4);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 pc back to zero", pc_o, 32'd0);
        chk("R1 store masked", {31'd0, st_en_o}, 32'd0);
    endtask

    task automatic test_arith();
        emit(e_i(O_ADDI, 5'd1, 5'd0, 16'd7));
        emit(e_i(O_ADDI, 5'd2, 5'd0, 16'hFFFD));
        emit(e_r(F_ADD, 5'd3, 5'd1, 5'd2));
        emit(e_r(F_SUB, 5'd4, 5'd1, 5'd2));
        emit(e_r(F_AND, 5'd5, 5'd1, 5'd2));
        emit(e_r(F_OR,  5'd6, 5'd1, 5'd2));
        emit(e_r(F_SLT, 5'd7, 5'd2, 5'd1));
        emit(e_r(F_SLT, 5'd8, 5'd1, 5'd2));
        for (int k = 0; k < 6; k++) emit(e_i(O_SW, 5'(3 + k), 5'd0, 16'(4 * k)));
        emit(e_i(O_SW, 5'd2, 5'd0, 16'd24));
        emit(e_j(O_J, 26'd15));
        boot();
        release_run(20);
        chk("R3 store count", 32'(cap_n), 32'd7);
        chk("R3 add", cap_d[0], 32'd4);
        chk("R3 sub", cap_d[1], 32'd10);
        chk("R3 and", cap_d[2], 32'd5);
        chk("R3 or", cap_d[3], 32'hFFFF_FFFF);
        chk("R4 slt signed true", cap_d[4], 32'd1);
        chk("R4 slt signed false", cap_d[5], 32'd0);
        chk("R5 addi negative imm", cap_d[6], 32'hFFFF_FFFD);
        chk("R6 store address", cap_a[6], 32'd24);
        chk("R2 R12 rd dest and forward", cap_d[0] + cap_d[1], 32'd14);
        chk("R7 halt pc", pc_o, 32'd60);
    endtask

    task automatic test_mem();
        emit(e_i(O_ADDI, 5'd1, 5'd0, 16'd8));
        emit(e_i(O_LW, 5'd9, 5'd1, 16'd12));
        emit(e_r(F_ADD, 5'd10, 5'd9, 5'd9));
        emit(e_i(O_SW, 5'd10, 5'd1, 16'hFFFC));
        emit(e_i(O_LW, 5'd11, 5'd0, 16'd4));
        emit(e_i(O_SW, 5'd11, 5'd0, 16'd32));
        emit(e_j(O_J, 26'd6));
        boot();
        ld_dmem_we = 1'b1;
        ld_addr    = 6'd5;
        ld_data    = 32'h1234_5678;
        @(negedge clk);
        // Load port driven while running: must be ignored (R11)
        ld_imem_we = 1'b1;
        ld_data    = 32'hDEAD_BEEF;
        rst   = 1'b0;
        cap_n = 0;
        repeat (6) @(negedge clk);
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
        repeat (6) @(negedge clk);
        #0.5;
        chk("R11 store count", 32'(cap_n), 32'd2);
        chk("R6 R11 load value doubled", cap_d[0], 32'h2468_ACF0);
        chk("R6 negative offset address", cap_a[0], 32'd4);
        chk("R6 store then load", cap_d[1], 32'h2468_ACF0);
        chk("R11 halt pc", pc_o, 32'd24);
    endtask

    task automatic test_branch();
        emit(e_i(O_ADDI, 5'd1, 5'd0, 16'd3));
        emit(e_i(O_ADDI, 5'd1, 5'd1, 16'hFFFF));
        emit(e_i(O_SW, 5'd1, 5'd0, 16'd0));
        emit(e_i(O_BEQ, 5'd0, 5'd1, 16'd1));
        emit(e_i(O_BEQ, 5'd0, 5'd0, 16'hFFFC));
        emit(e_i(O_SW, 5'd1, 5'd0, 16'd4));
        emit(e_j(O_J, 26'd6));
        boot();
        release_run(25);
        chk("R7 store count", 32'(cap_n), 32'd4);
        chk("R7 loop pass 1", cap_d[0], 32'd2);
        chk("R7 loop pass 2", cap_d[1], 32'd1);
        chk("R7 loop pass 3", cap_d[2], 32'd0);
        chk("R7 taken exit address", cap_a[3], 32'd4);
        chk("R7 halt pc", pc_o, 32'd24);
    endtask

    task automatic test_jump();
        emit(e_j(O_JAL, 26'd4));
        for (int k = 0; k < 3; k++) emit(e_i(O_SW, 5'd5, 5'd0, 16'd60));
        emit(e_i(O_SW, 5'd31, 5'd0, 16'd0));
        emit(e_i(O_ADDI, 5'd0, 5'd0, 16'd5));
        emit(e_i(O_SW, 5'd0, 5'd0, 16'd8));
        emit(e_j(O_J, 26'd10));
        emit(e_i(O_ADDI, 5'd31, 5'd0, 16'd1));
        emit(e_i(O_SW, 5'd5, 5'd0, 16'd60));
        emit(e_i(O_SW, 5'd31, 5'd0, 16'd12));
        emit(e_j(O_J, 26'd11));
        boot();
        release_run(12);
        chk("R8 store count", 32'(cap_n), 32'd3);
        chk("R9 link value", cap_d[0], 32'd4);
        chk("R10 r0 stays zero", cap_d[1], 32'd0);
        chk("R8 jump skipped write", cap_d[2], 32'd4);
        chk("R8 halt pc", pc_o, 32'd44);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        test_arith();
        test_mem();
        test_branch();
        test_jump();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule